// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog and Cause Flag

This block produces the active-low processor reset for a small power-management controller. A reset is requested when the supervised supply is reported bad, when the push-button reset is pressed, when the built-in watchdog sees no strobe activity for a full timeout, or when a second, external watchdog raises its request line. After every request clears, the reset output stays low for a fixed hold period and is then released.

The built-in watchdog restarts on every change of the strobe input, in either direction. It is switched off when the strobe driver reports that it is floating and the force-enable pin is low. A one-bit cause flag lets the processor tell a supply or button reset apart from a watchdog reset. The flag clears itself after a fixed time once the reset has been released. All timeouts are parameters counted in cycles of the reference clock. The button, strobe, strobe-driven and force-enable pins pass through a two-flop synchronizer. The supply flag and the external watchdog request are taken as already synchronous.

Top module: `rst_supervisor`

## Requirements
- R1: While the block reset `rst_n` is low, `sys_rst_n_o` is 0 and `rst_cause_o` is 0. With the supply good and the button released, `sys_rst_n_o` rises on the HOLD_CYCLES-th rising clock edge after `rst_n` goes high.
- R2: If `supply_ok_i` is 0 at a rising edge, `sys_rst_n_o` is 0 after that edge. Once `supply_ok_i` returns to 1, `sys_rst_n_o` rises on the HOLD_CYCLES-th rising edge.
- R3: When `btn_n_i` goes low, `sys_rst_n_o` is 0 after the third rising edge: two synchronizer stages plus one register. When `btn_n_i` returns high, `sys_rst_n_o` rises on rising edge HOLD_CYCLES+2.
- R4: Rising and falling transitions of `strobe_i` both restart the watchdog. Transitions spaced at most WD_CYCLES clock cycles apart never cause a reset. A spacing of WD_CYCLES+1 cycles does cause one.
- R5: If `strobe_i` makes no transition after its last one, `sys_rst_n_o` goes to 0 on rising edge WD_CYCLES+3 after that transition.
- R6: With `strobe_drv_i`=0 and `wd_force_i`=0 the watchdog never fires. If `wd_force_i` then rises with no strobe activity, `sys_rst_n_o` goes to 0 on rising edge WD_CYCLES+2.
- R7: The watchdog is held cleared while the reset is asserted. With no strobe activity, reset asserts again exactly WD_CYCLES rising edges after its release.
- R8: `ext_wd_req_i`=1 at a rising edge drives `sys_rst_n_o` to 0 after that edge and sets `rst_cause_o` to 1.
- R9: `rst_cause_o` encodes 0 for a supply or button reset and 1 for a watchdog reset, whether internal or external. When a watchdog request coincides with another cause, the flag is 1. A new supply or button reset entered while the flag is 1 sets it back to 0.
- R10: After a watchdog reset is released, `rst_cause_o` returns to 0 on the STATUS_CYCLES-th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok_i | input | 1 | Supervised rail above threshold (synchronous) |
| btn_n_i | input | 1 | Push-button reset, active low (asynchronous) |
| strobe_i | input | 1 | Watchdog strobe from the processor (asynchronous) |
| strobe_drv_i | input | 1 | 1 when the strobe line is actively driven |
| wd_force_i | input | 1 | Keeps the watchdog enabled even when the strobe floats |
| ext_wd_req_i | input | 1 | Reset request from the second watchdog (synchronous) |
| sys_rst_n_o | output | 1 | Processor reset, active low |
| rst_cause_o | output | 1 | Cause of the last reset: 0 supply/button, 1 watchdog |

## Verification
The bench builds the block with WD_CYCLES=8, HOLD_CYCLES=5 and STATUS_CYCLES=6. At these values every timeout is a handful of cycles, so each edge count can be compared exactly against a formula. Strobe spacings are swept from 1 up to one past the watchdog limit, which exercises the boundary between staying alive and expiring. The short status time ends before the watchdog runs out again, so both the self-clearing of the flag and the re-expiry after release can be seen in one run.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  typedef enum logic {
    CAUSE_SUPPLY = 1'b0,
    CAUSE_WDOG   = 1'b1
  } cause_e;

  // Counter width needed to hold values 0 .. n-1
  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;

endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog
  import rsup_pkg::*;
#(
  parameter int WD_CYCLES = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_s_i,
  input  logic en_i,
  input  logic hold_clr_i,
  output logic edge_o,
  output logic fire_o
);

  localparam int CW = cnt_w(WD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WD_CYCLES - 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          clr;

  assign edge_o = strobe_s_i ^ prev_q;
  assign clr    = hold_clr_i | ~en_i | edge_o;
  assign fire_o = ~clr & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= strobe_s_i;
      if (clr || fire_o) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: a disabled watchdog never fires
  assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !fire_o);

  // R7: no expiry while the reset is held
  assert_quiet_in_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr_i |-> !fire_o);

  generate
    if (WD_CYCLES >= 2) begin : g_edge_chk
      // R4: a strobe transition restarts the count, so no expiry next cycle
      assert_edge_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !fire_o);
    end
  endgenerate

endmodule

// File: rtl/rsup_hold.sv
module rsup_hold
  import rsup_pkg::*;
#(
  parameter int HOLD_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rst_o
);

  localparam int CW = cnt_w(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic          rst_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (req_i) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (rst_q) begin
      if (cnt_q == LAST) begin
        rst_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_o = rst_q;

  // R2: any request puts the reset into force at the next edge
  assert_req_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> rst_o);

  // R2: release only happens after a request-free cycle
  assert_release_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> !$past(req_i));

endmodule

// File: rtl/rsup_cause.sv
module rsup_cause
  import rsup_pkg::*;
#(
  parameter int STATUS_CYCLES = 1000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_i,
  input  logic   wd_req_i,
  input  logic   in_rst_i,
  output cause_e cause_o
);

  localparam int CW = cnt_w(STATUS_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(STATUS_CYCLES - 1);

  cause_e        cause_q;
  logic [CW-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_SUPPLY;
      stat_q  <= '0;
    end else if (req_i) begin
      stat_q <= '0;
      if (wd_req_i)       cause_q <= CAUSE_WDOG;
      else if (!in_rst_i) cause_q <= CAUSE_SUPPLY;
    end else if (in_rst_i) begin
      stat_q <= '0;
    end else if (cause_q == CAUSE_WDOG) begin
      if (stat_q == LAST) begin
        cause_q <= CAUSE_SUPPLY;
        stat_q  <= '0;
      end else begin
        stat_q <= stat_q + 1'b1;
      end
    end
  end

  assign cause_o = cause_q;

  // R8: a watchdog request always leaves the flag set
  assert_wd_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_req_i |=> (cause_o == CAUSE_WDOG));

  // R10: the flag drops only by timeout outside reset or on a new reset entry
  assert_clear_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cause_o) |-> ($past(req_i) || !$past(in_rst_i)));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsup_pkg::*;
#(
  parameter int WD_CYCLES     = 1600,
  parameter int HOLD_CYCLES   = 200,
  parameter int STATUS_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic btn_n_i,
  input  logic strobe_i,
  input  logic strobe_drv_i,
  input  logic wd_force_i,
  input  logic ext_wd_req_i,
  output logic sys_rst_n_o,
  output logic rst_cause_o
);

  // synchronized bundle: [3] strobe driven, [2] force, [1] strobe, [0] button
  localparam int SW = 4;

  logic [SW-1:0] raw_in, sync_in;
  logic          btn_active, strobe_s, wd_en;
  logic          wd_edge, wd_fire;
  logic          wd_req, any_req, rst_q;
  cause_e        cause_q;

  assign raw_in = {strobe_drv_i, wd_force_i, strobe_i, btn_n_i};

  rsup_sync #(.W(SW), .RST_VAL(4'b0001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign btn_active = ~sync_in[0];
  assign strobe_s   = sync_in[1];
  assign wd_en      = sync_in[3] | sync_in[2];

  rsup_wdog #(.WD_CYCLES(WD_CYCLES)) u_wdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_s_i (strobe_s),
    .en_i       (wd_en),
    .hold_clr_i (rst_q),
    .edge_o     (wd_edge),
    .fire_o     (wd_fire)
  );

  assign wd_req  = wd_fire | ext_wd_req_i;
  assign any_req = ~supply_ok_i | btn_active | wd_req;

  rsup_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (any_req),
    .rst_o (rst_q)
  );

  rsup_cause #(.STATUS_CYCLES(STATUS_CYCLES)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (any_req),
    .wd_req_i (wd_req),
    .in_rst_i (rst_q),
    .cause_o  (cause_q)
  );

  assign sys_rst_n_o = ~rst_q;
  assign rst_cause_o = cause_q;

  // R9: the watchdog flag is only raised together with an asserted reset
  assert_cause_with_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_cause_o) |-> !sys_rst_n_o);

  // R3: a pressed button keeps the reset asserted
  assert_button_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    btn_active |=> !sys_rst_n_o);

  // R4: a strobe transition never coincides with an expiry
  assert_edge_no_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_edge |-> !wd_fire);

endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;

  localparam int WD   = 8;
  localparam int HOLD = 5;
  localparam int STAT = 6;

  logic clk = 1'b0;
  logic rst_n, supply_ok, btn_n, strobe, strobe_drv, wd_force, ext_wd;
  logic sys_rst_n, cause;

  int n_chk  = 0;
  int n_fail = 0;
  int per    = 2;
  bit tog_en = 1'b0;

  always #5 clk = ~clk;

  rst_supervisor #(.WD_CYCLES(WD), .HOLD_CYCLES(HOLD), .STATUS_CYCLES(STAT)) u_rst_supervisor (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok_i  (supply_ok),
    .btn_n_i      (btn_n),
    .strobe_i     (strobe),
    .strobe_drv_i (strobe_drv),
    .wd_force_i   (wd_force),
    .ext_wd_req_i (ext_wd),
    .sys_rst_n_o  (sys_rst_n),
    .rst_cause_o  (cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count rising edges until sys_rst_n takes the wanted value
  task automatic until_rst(input logic want, output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      n++;
      if (sys_rst_n == want) break;
    end
  endtask

  task automatic until_cause(input logic want, output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      n++;
      if (cause == want) break;
    end
  endtask

  task automatic count_low(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (!sys_rst_n) lows++;
    end
  endtask

  // background strobe toggler: one transition every per cycles
  initial begin
    int tcnt = 0;
    forever begin
      @(negedge clk);
      if (tog_en) begin
        tcnt++;
        if (tcnt >= per) begin
          strobe = ~strobe;
          tcnt = 0;
        end
      end else begin
        tcnt = 0;
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, m, lows;
    rst_n = 1'b0; supply_ok = 1'b1; btn_n = 1'b1; strobe = 1'b0;
    strobe_drv = 1'b1; wd_force = 1'b0; ext_wd = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset low during block reset", int'(sys_rst_n), 0);
    chk("R1 cause zero during block reset", int'(cause), 0);

    @(negedge clk);
    rst_n = 1'b1; per = 2; tog_en = 1'b1;
    until_rst(1'b1, n);
    chk("R1 release edges after block reset", n, HOLD);
    chk("R1 cause after power-up", int'(cause), 0);

    // R2 supply
    @(negedge clk); supply_ok = 1'b0;
    until_rst(1'b0, n);
    chk("R2 assert edges on supply loss", n, 1);
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    until_rst(1'b1, n);
    chk("R2 release edges after supply return", n, HOLD);

    // R3 button
    @(negedge clk); btn_n = 1'b0;
    until_rst(1'b0, n);
    chk("R3 assert edges on button", n, 3);
    repeat (4) @(negedge clk);
    btn_n = 1'b1;
    until_rst(1'b1, n);
    chk("R3 release edges after button", n, HOLD + 2);
    chk("R9 cause after button reset", int'(cause), 0);

    // R4 sweep of strobe spacing
    for (int p = 1; p <= WD + 1; p++) begin
      @(negedge clk); per = p;
      count_low(5 * WD, lows);
      if (p <= WD) chk($sformatf("R4 no reset at spacing %0d", p), lows, 0);
      else         chk($sformatf("R4 reset at spacing %0d", p), int'(lows > 0), 1);
    end
    @(negedge clk); per = 2;
    count_low(40, lows);
    count_low(10, lows);
    chk("R4 recovered with fast strobe", lows, 0);

    // R5 exact expiry, R10 status timeout, R7 re-expiry after release
    @(negedge clk); tog_en = 1'b0;
    repeat (2) @(negedge clk);
    strobe = ~strobe;
    until_rst(1'b0, n);
    chk("R5 expiry edges after last transition", n, WD + 3);
    chk("R9 cause after watchdog expiry", int'(cause), 1);
    until_rst(1'b1, n);
    chk("R5 release after watchdog reset", n, HOLD);
    until_cause(1'b0, n);
    chk("R10 status clear edges after release", n, STAT);
    until_rst(1'b0, m);
    chk("R7 re-expiry edges after release", n + m, WD);

    // R6 disable
    @(negedge clk); strobe_drv = 1'b0; wd_force = 1'b0;
    until_rst(1'b1, n);
    count_low(8 * WD, lows);
    chk("R6 no expiry while disabled", lows, 0);
    @(negedge clk); wd_force = 1'b1;
    until_rst(1'b0, n);
    chk("R6 expiry edges after force enable", n, WD + 2);

    // restore driven strobe
    @(negedge clk); wd_force = 1'b0; strobe_drv = 1'b1; per = 2; tog_en = 1'b1;
    until_rst(1'b1, n);
    repeat (STAT + 2) @(negedge clk);
    count_low(3 * WD, lows);
    chk("R4 alive after restore", lows, 0);
    chk("R10 cause cleared before external request", int'(cause), 0);

    // R8 external watchdog
    @(negedge clk); ext_wd = 1'b1;
    until_rst(1'b0, n);
    @(negedge clk); ext_wd = 1'b0;
    chk("R8 assert edges on external request", n, 1);
    chk("R8 cause after external request", int'(cause), 1);
    until_rst(1'b1, n);
    chk("R8 release edges after external request", n, HOLD);

    // R9 supply reset while watchdog flag still set
    @(negedge clk); supply_ok = 1'b0;
    until_rst(1'b0, n);
    chk("R9 cause replaced by supply reset", int'(cause), 0);
    @(negedge clk); supply_ok = 1'b1;
    until_rst(1'b1, n);

    // R9 priority: watchdog and supply together
    @(negedge clk); supply_ok = 1'b0; ext_wd = 1'b1;
    @(negedge clk); ext_wd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 watchdog wins over supply cause", int'(cause), 1);
    chk("R9 reset held during supply loss", int'(sys_rst_n), 0);
    supply_ok = 1'b1;
    until_rst(1'b1, n);
    chk("R2 release after combined reset", n, HOLD);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule